// File: doc/BRIEF.md
# Serial Register-Access Slave

This block is the peripheral end of a four-wire serial control link that gives a master read and write access to a small bank of 8-bit registers. The master selects the peripheral by pulling an active-low select line low. It then shifts a request frame onto a single request wire, one bit per clock. The slave answers on two wires of its own: a response line that carries read data and an acknowledge line that marks the end of each transaction. The link is half-duplex. The master must wait for the acknowledge before it releases select. The master counts no cycles, so the slave's response latency can change without breaking the master.

There are ten registers. Five are writable configuration registers, such as weights, a bias, an input value and a control byte. Their contents are presented on a parallel output to the logic they configure. The other five are read-only observation registers, such as status, a result and intermediate arithmetic values. The surrounding datapath supplies them through a parallel input. There is only one peripheral, so the response and acknowledge lines are driven directly and are never tri-stated. The select and request wires arrive from another clock domain and are synchronized before the slave decodes them.

Top module: `sci_reg_slave`

## Requirements
- R1: While reset is asserted and after it is released, all writable registers read 0x00, and the response and acknowledge outputs are low.
- R2: A frame is sampled MSB first while select is low, one bit per rising edge, after a two-flop synchronizer on each input. The first bit is the direction (1 = write, 0 = read). Four address bits follow. A write then carries 8 data bits.
- R3: A write to address 0..4 stores the data byte in writable register k = address. Register k appears on `rw_q_o[8k+7:8k]` in the same cycle as the acknowledge.
- R4: A write is acknowledged by a single-cycle pulse on `ack_o`. The pulse is high in the cycle after the rising edge that lies two edges after the edge on which the last data bit was presented.
- R5: A read returns 8 bits on `resp_o`, MSB first, one per cycle. If the last address bit is presented before edge h, data bit j (j = 0 is the MSB) is visible after edge h+3+j. `ack_o` is high only together with the last bit.
- R6: A read of address 5+k (k = 0..4) returns `ro_d_i[8k+7:8k]`.
- R7: A read of address 10..15 returns 0x00.
- R8: A write to address 5..15 is acknowledged like any other write, and no writable register changes.
- R9: If select rises before a frame completes, the frame is dropped. No acknowledge is given, no register changes, and the next frame is decoded normally.
- R10: Once a transaction has completed, the slave ignores the request line until select is released. Outside the read-data window, `resp_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_n_i | input | 1 | Active-low peripheral select from the master |
| req_i | input | 1 | Serial request bits from the master |
| resp_o | output | 1 | Serial read data to the master |
| ack_o | output | 1 | Transaction acknowledge to the master |
| ro_d_i | input | 40 | Five read-only register values, register k in bits 8k+7:8k |
| rw_q_o | output | 40 | Five writable register contents, register k in bits 8k+7:8k |

## Verification
Every frame bit is presented on a falling edge. Because of the two synchronizer stages, a bit presented before rising edge i is decoded at edge i+2. The write acknowledge and the register update are therefore checked one half cycle after the 14th edge of the frame. The checks also confirm that the acknowledge is low one cycle before and one cycle after. For reads, the response line is checked to be low one cycle before the first data bit. Each of the eight data bits is then sampled in turn, starting half a cycle after edge 7 of the frame, and the acknowledge is checked to coincide only with the last one. These windows are repeated after every gap between frames and after every hold time of select, so each result is checked at a fixed cycle offset.

// File: rtl/sci_pkg.sv
package sci_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECV,
    ST_READ,
    ST_DONE
  } sci_state_e;
endpackage

// File: rtl/sci_sync.sv
module sci_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[b];
        sync_q <= RST_VAL[b];
      end else begin
        meta_q <= d_i[b];
        sync_q <= meta_q;
      end
    end
    assign q_o[b] = sync_q;
  end
endmodule

// File: rtl/sci_frame_fsm.sv
module sci_frame_fsm
  import sci_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_s,
  input  logic              req_s,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              resp_o,
  output logic              ack_o
);
  localparam int HDR_BITS   = 1 + ADDR_W;
  localparam int FRAME_BITS = HDR_BITS + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] HDR_LAST   = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] DATA_LAST  = CNT_W'(DATA_W - 1);

  sci_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              resp_q, resp_d;
  logic              ack_q, ack_d;
  logic [ADDR_W-1:0] hdr_addr;
  logic              hdr_end;
  logic              we;

  assign hdr_addr = {sh_q[ADDR_W-2:0], req_s};
  assign hdr_end  = (state_q == ST_RECV) && (cnt_q == HDR_LAST);
  assign addr_o   = hdr_end ? hdr_addr : addr_q;
  assign wdata_o  = {sh_q[DATA_W-2:0], req_s};
  assign we_o     = we;
  assign resp_o   = resp_q;
  assign ack_o    = ack_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    addr_d  = addr_q;
    resp_d  = 1'b0;
    ack_d   = 1'b0;
    we      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (!csn_s) begin
          sh_d    = {sh_q[DATA_W-2:0], req_s};
          cnt_d   = CNT_W'(1);
          state_d = ST_RECV;
        end
      end
      ST_RECV: begin
        if (csn_s) begin
          state_d = ST_IDLE;
        end else begin
          sh_d  = {sh_q[DATA_W-2:0], req_s};
          cnt_d = cnt_q + CNT_W'(1);
          if (cnt_q == HDR_LAST) begin
            addr_d = hdr_addr;
            if (!sh_q[ADDR_W-1]) begin
              state_d = ST_READ;
              tx_d    = rd_data_i;
              cnt_d   = '0;
            end
          end else if (cnt_q == FRAME_LAST) begin
            we      = 1'b1;
            ack_d   = 1'b1;
            state_d = ST_DONE;
          end
        end
      end
      ST_READ: begin
        if (csn_s) begin
          state_d = ST_IDLE;
        end else begin
          resp_d = tx_q[DATA_W-1];
          tx_d   = {tx_q[DATA_W-2:0], 1'b0};
          cnt_d  = cnt_q + CNT_W'(1);
          if (cnt_q == DATA_LAST) begin
            ack_d   = 1'b1;
            state_d = ST_DONE;
          end
        end
      end
      ST_DONE: begin
        if (csn_s) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      addr_q  <= '0;
      resp_q  <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      addr_q  <= addr_d;
      resp_q  <= resp_d;
      ack_q   <= ack_d;
    end
  end

  // R4: acknowledge never lasts longer than one cycle
  p_ack_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);

  // R9: select rising inside a frame returns to idle with no acknowledge
  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RECV && csn_s) |=> (state_q == ST_IDLE && !ack_q));

  // R10: idle slave keeps both return wires low
  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (!resp_q && !ack_q));

  // R3: a register write is followed by the acknowledge and the done state
  p_write_acked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (ack_q && state_q == ST_DONE));
endmodule

// File: rtl/sci_regbank.sv
module sci_regbank #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int N_RW   = 5,
  parameter int N_RO   = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic [N_RO*DATA_W-1:0] ro_d_i,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic [N_RW*DATA_W-1:0] rw_q_o
);
  for (genvar i = 0; i < N_RW; i++) begin : g_rw
    logic [DATA_W-1:0] reg_q, reg_d;
    logic              hit;
    assign hit = we_i && (addr_i == ADDR_W'(i));
    always_comb reg_d = hit ? wdata_i : reg_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_q <= '0;
      else        reg_q <= reg_d;
    end
    assign rw_q_o[i*DATA_W +: DATA_W] = reg_q;
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < N_RW; i++) begin
      if (addr_i == ADDR_W'(i)) rd_data_o = rw_q_o[i*DATA_W +: DATA_W];
    end
    for (int j = 0; j < N_RO; j++) begin
      if (addr_i == ADDR_W'(N_RW + j)) rd_data_o = ro_d_i[j*DATA_W +: DATA_W];
    end
  end

  // R8: writes outside the writable range leave every register untouched
  p_ro_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && (int'(addr_i) >= N_RW)) |=> $stable(rw_q_o));

  // R3: writable contents change only on a write strobe
  p_change_needs_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rw_q_o) |-> $past(we_i));
endmodule

// File: rtl/sci_reg_slave.sv
module sci_reg_slave #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int N_RW   = 5,
  parameter int N_RO   = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sel_n_i,
  input  logic                   req_i,
  output logic                   resp_o,
  output logic                   ack_o,
  input  logic [N_RO*DATA_W-1:0] ro_d_i,
  output logic [N_RW*DATA_W-1:0] rw_q_o
);
  localparam int N_REGS = N_RW + N_RO;

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic [1:0]        pins_s;
  logic              csn_s, req_s;
  logic [ADDR_W-1:0] addr;
  logic              we;
  logic [DATA_W-1:0] wdata, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  sci_sync #(.W(2), .RST_VAL(2'b10)) i_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   ({sel_n_i, req_i}),
    .q_o   (pins_s)
  );
  assign csn_s = pins_s[1];
  assign req_s = pins_s[0];

  sci_frame_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .csn_s     (csn_s),
    .req_s     (req_s),
    .rd_data_i (rd_data),
    .addr_o    (addr),
    .we_o      (we),
    .wdata_o   (wdata),
    .resp_o    (resp_o),
    .ack_o     (ack_o)
  );

  sci_regbank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_RW(N_RW), .N_RO(N_RO)) i_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .we_i      (we),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .ro_d_i    (ro_d_i),
    .rd_data_o (rd_data),
    .rw_q_o    (rw_q_o)
  );

  // R1: map must fit the address space
  initial begin
    p_map_fits_r1: assert (N_REGS <= (1 << ADDR_W));
  end

  // R1: outputs stay low while the internal reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_sync_n |-> (!ack_o && !resp_o && rw_q_o == '0));
endmodule

// File: tb/test_sci_reg_slave.sv
`timescale 1ns/1ps
module test_sci_reg_slave;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel_n, req;
  logic        resp, ack;
  logic [39:0] ro_d;
  logic [39:0] rw_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [7:0] model [5];

  always #2.5 clk = ~clk;

  sci_reg_slave i_sci_reg_slave (
    .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .req_i(req),
    .resp_o(resp), .ack_o(ack), .ro_d_i(ro_d), .rw_q_o(rw_q)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", rq, what, act, exp);
    end
  endtask

  task automatic check_regs(input string rq);
    for (int k = 0; k < 5; k++)
      check(rw_q[8*k +: 8] == model[k], rq, "writable register", rw_q[8*k +: 8], model[k]);
  endtask

  function automatic logic [7:0] expect_rd(input int a);
    if (a < 5)  return model[a];
    if (a < 10) return ro_d[8*(a-5) +: 8];
    return 8'h00;
  endfunction

  // R2: one bit per falling edge, MSB first
  task automatic send(input logic [12:0] frame, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sel_n = 1'b0;
      req   = frame[n-1-i];
    end
  endtask

  task automatic release_sel(input int gap);
    sel_n = 1'b1;
    req   = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic hold_done(input int hold);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      req = ~req;
      check(!ack && !resp, "R10", "quiet while select held", {ack, resp}, 0);
    end
  endtask

  task automatic do_write(input int a, input logic [7:0] d, input int gap, input int hold);
    send({1'b1, 4'(a), d}, 13);
    @(negedge clk); req = 1'b0;
    @(negedge clk);
    check(!ack, "R4", "ack early", ack, 0);
    @(negedge clk);
    if (a < 5) model[a] = d;
    check(ack, (a < 5) ? "R4" : "R8", "write ack", ack, 1);
    check_regs((a < 5) ? "R3" : "R8");
    @(negedge clk);
    check(!ack, "R4", "ack one cycle", ack, 0);
    hold_done(hold);
    release_sel(gap);
  endtask

  task automatic do_read(input int a, input int gap, input int hold);
    logic [7:0] got, exp;
    int ack_bad;
    exp = expect_rd(a);
    got = '0;
    ack_bad = 0;
    send({8'h00, 1'b0, 4'(a)}, 5);
    @(negedge clk); req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(!resp && !ack, "R10", "resp low before data", {ack, resp}, 0);
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      got = {got[6:0], resp};
      if (ack != (j == 7)) ack_bad++;
    end
    check(ack_bad == 0, "R5", "ack only with last bit", ack_bad, 0);
    if (a < 5)       check(got == exp, "R5", "read writable", got, exp);
    else if (a < 10) check(got == exp, "R6", "read observation", got, exp);
    else             check(got == exp, "R7", "read unmapped", got, exp);
    @(negedge clk);
    check(!ack && !resp, "R10", "quiet after read", {ack, resp}, 0);
    hold_done(hold);
    release_sel(gap);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int ab;
    rst_n = 1'b0;
    sel_n = 1'b1;
    req   = 1'b0;
    ro_d  = 40'h0;
    for (int k = 0; k < 5; k++) model[k] = 8'h00;
    repeat (3) @(negedge clk);
    check(!ack && !resp, "R1", "outputs in reset", {ack, resp}, 0);
    check_regs("R1");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!ack && !resp, "R1", "outputs after reset", {ack, resp}, 0);
    check_regs("R1");

    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < 5; k++) ro_d[8*k +: 8] = 8'((k * 53 + p * 29 + 17) ^ (p * 8'hA5));
      for (int a = 0; a < 16; a++)
        do_write(a, 8'(a * 37 + p * 91 + 5), 1 + (a % 4), a % 3);
      for (int a = 0; a < 16; a++)
        do_read(a, 1 + ((a + p) % 4), (a + 1) % 3);
    end

    // R9: write aborted after a varying number of bits
    for (int n = 1; n < 13; n++) begin
      ab = 0;
      send({1'b1, 4'(n % 5), 8'hC3}, n);
      sel_n = 1'b1;
      req = 1'b0;
      repeat (5) begin
        @(negedge clk);
        if (ack) ab++;
      end
      check(ab == 0, "R9", "no ack on abort", ab, 0);
      check_regs("R9");
    end

    // R9: read aborted inside the data window, then normal traffic resumes
    send({8'h00, 1'b0, 4'd2}, 5);
    repeat (9) @(negedge clk);
    release_sel(3);
    check(!ack && !resp, "R9", "quiet after read abort", {ack, resp}, 0);
    do_write(2, 8'h5A, 2, 0);
    do_read(2, 2, 0);
    do_write(4, 8'hFF, 1, 4);
    do_read(4, 1, 4);
    do_write(0, 8'h80, 1, 0);
    do_read(0, 1, 0);

    finish_run();
  end
endmodule